// File: doc/BRIEF.md
# Six-State Accumulator Microcomputer

This block is a small stored-program computer. A 4-bit program counter, a 4-bit memory address register, a 16-word by 8-bit memory, an 8-bit instruction register, an accumulator, an operand register, an add/subtract unit and an 8-bit output register all exchange data over one shared 8-bit bus. A one-hot ring of six timing states sequences every instruction. The first three states fetch the instruction and the last three execute it. The machine has no branches, so it runs straight through memory from address 0.

Each instruction word holds an opcode in its upper nibble and a memory address in its lower nibble. The memory holds both the program and its data. The memory image is written through a preload port, and only while the start input holds the machine in clear. When start drops, the machine runs until it meets a halt instruction. It then freezes with the halted flag raised and the last value written by an output instruction still presented.

Top module: `acc_micro`

## Requirements
- R1: While `start` is high, the machine is cleared at each clock edge: program counter 0, timing state T0, `out_val` 0 and `halted` 0. After `start` falls, execution begins at address 0.
- R2: A preload write (`ld_we`) stores `ld_data` at `ld_addr` only while `start` is high. Writes attempted while the machine runs leave memory unchanged.
- R3: Every instruction takes exactly six clock edges. For the instruction at position i (counting from 0), the execute action of its first execute state (T3) takes effect on edge 6i+4 after `start` falls.
- R4: Opcode 0000 (load) copies memory[operand] into the accumulator. Opcode 1110 (output) copies the accumulator into `out_val` on that instruction's T3 edge, and at no other time.
- R5: Opcode 0001 (add) loads memory[operand] into the operand register and then writes accumulator + operand, modulo 256, into the accumulator.
- R6: Opcode 0010 (subtract) does the same as add, but writes accumulator − operand modulo 256.
- R7: Opcode 1111 (halt) sets `halted`. After that no register changes and `out_val` stays stable until `start` is raised again.
- R8: Opcodes 0011 through 1101 are no-operations: they change neither the accumulator nor `out_val`.
- R9: The low nibble of the output and halt instructions has no effect.
- R10: The program 09,1A,1B,1C,2D,E0,F0, with data 16,20,24,28,32 at addresses 9 to D, leaves 56 in `out_val` with `halted` set on edge 40.
- R11: In any state at most one bus driver is enabled, and the bus reads 0 when none is.
- R12: Raising `start` during a run clears the machine as in R1. Memory keeps its contents, so releasing `start` reruns the program from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| start | input | 1 | Synchronous clear while high; the machine runs from address 0 once it falls |
| ld_we | input | 1 | Preload write enable, honoured only while `start` is high |
| ld_addr | input | 4 | Preload word address |
| ld_data | input | 8 | Preload word value |
| out_val | output | 8 | Output register contents |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The hardest case to reach from the ports is a preload write arriving while the machine runs. From outside, it can only be seen by its absence. The bench drives `ld_we` to overwrite a data word in the middle of a run. It then confirms at the output that the original value was loaded, and confirms it again after a clear-and-rerun. A second hard case is the exact instant of the output and halt actions. The bench counts edges from the release of `start` and samples on the edge just before and the edge just after each action.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int DW = 8;        // data / bus width
    localparam int AW = 4;        // address width
    localparam int NT = 6;        // timing states per instruction
    localparam int OW = DW - AW;  // opcode width
    localparam int MD = 1 << AW;  // memory depth

    localparam logic [OW-1:0] OPC_LOAD = 4'b0000;
    localparam logic [OW-1:0] OPC_ADD  = 4'b0001;
    localparam logic [OW-1:0] OPC_SUB  = 4'b0010;
    localparam logic [OW-1:0] OPC_OUT  = 4'b1110;
    localparam logic [OW-1:0] OPC_STOP = 4'b1111;

    // control word: one bit per micro-action
    typedef struct packed {
        logic pc_inc;
        logic pc_oe;
        logic mar_ld;
        logic mem_oe;
        logic ir_ld;
        logic ir_oe;
        logic acc_ld;
        logic acc_oe;
        logic alu_sub;
        logic alu_oe;
        logic opr_ld;
        logic out_ld;
        logic stop;
    } ctl_t;

    function automatic logic uses_memory(input logic [OW-1:0] op);
        return (op == OPC_LOAD) || (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

    function automatic logic is_arith(input logic [OW-1:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

endpackage

// File: rtl/acc_ring.sv
module acc_ring #(
    parameter int N = acc_pkg::NT
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         adv,
    output logic [N-1:0] tst
);
    always_ff @(posedge clk) begin
        if (clr)
            tst <= {{(N-1){1'b0}}, 1'b1};
        else if (adv)
            tst <= {tst[N-2:0], tst[N-1]};
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic [NT-1:0] tst,
    input  logic [OW-1:0] op,
    input  logic          halted,
    output ctl_t          ctl
);
    always_comb begin
        ctl = '0;
        if (!halted) begin
            // fetch
            if (tst[0]) begin
                ctl.pc_oe  = 1'b1;
                ctl.mar_ld = 1'b1;
            end
            if (tst[1]) begin
                ctl.mem_oe = 1'b1;
                ctl.ir_ld  = 1'b1;
            end
            if (tst[2])
                ctl.pc_inc = 1'b1;
            // execute
            if (tst[3]) begin
                if (uses_memory(op)) begin
                    ctl.ir_oe  = 1'b1;
                    ctl.mar_ld = 1'b1;
                end else if (op == OPC_OUT) begin
                    ctl.acc_oe = 1'b1;
                    ctl.out_ld = 1'b1;
                end else if (op == OPC_STOP) begin
                    ctl.stop = 1'b1;
                end
            end
            if (tst[4] && uses_memory(op)) begin
                ctl.mem_oe = 1'b1;
                if (op == OPC_LOAD) ctl.acc_ld = 1'b1;
                else                ctl.opr_ld = 1'b1;
            end
            if (tst[5] && is_arith(op)) begin
                ctl.alu_oe  = 1'b1;
                ctl.acc_ld  = 1'b1;
                ctl.alu_sub = (op == OPC_SUB);
            end
        end
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
(
    input  logic          clk,
    input  logic          clr,
    input  ctl_t          ctl,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [OW-1:0] op,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] bus,
    output logic [DW-1:0] out_val,
    output logic          halted
);
    logic [AW-1:0] mar;
    logic [DW-1:0] ir, acc, opr, alu, rd;
    logic [DW-1:0] mem [MD];

    // preload port, honoured only in clear
    always_ff @(posedge clk) begin
        if (clr && ld_we)
            mem[ld_addr] <= ld_data;
    end

    assign rd  = mem[mar];
    assign op  = ir[DW-1:AW];
    assign alu = ctl.alu_sub ? (acc - opr) : (acc + opr);

    // shared bus: OR of gated sources, zero when nothing drives
    always_comb begin
        bus = '0;
        bus |= {DW{ctl.pc_oe}}  & {{(DW-AW){1'b0}}, pc};
        bus |= {DW{ctl.mem_oe}} & rd;
        bus |= {DW{ctl.ir_oe}}  & {{(DW-AW){1'b0}}, ir[AW-1:0]};
        bus |= {DW{ctl.acc_oe}} & acc;
        bus |= {DW{ctl.alu_oe}} & alu;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            pc      <= '0;
            mar     <= '0;
            ir      <= '0;
            acc     <= '0;
            opr     <= '0;
            out_val <= '0;
            halted  <= 1'b0;
        end else begin
            if (ctl.pc_inc) pc      <= pc + 1'b1;
            if (ctl.mar_ld) mar     <= bus[AW-1:0];
            if (ctl.ir_ld)  ir      <= bus;
            if (ctl.acc_ld) acc     <= bus;
            if (ctl.opr_ld) opr     <= bus;
            if (ctl.out_ld) out_val <= bus;
            if (ctl.stop)   halted  <= 1'b1;
        end
    end
endmodule

// File: rtl/acc_micro.sv
module acc_micro
    import acc_pkg::*;
(
    input  logic          clk,
    input  logic          start,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] out_val,
    output logic          halted
);
    logic [NT-1:0] tst;
    logic [OW-1:0] op;
    logic [AW-1:0] pc;
    logic [DW-1:0] bus;
    ctl_t          ctl;

    acc_ring #(.N(NT)) u_ring (
        .clk (clk),
        .clr (start),
        .adv (!halted),
        .tst (tst)
    );

    acc_ctrl u_ctrl (
        .tst    (tst),
        .op     (op),
        .halted (halted),
        .ctl    (ctl)
    );

    acc_datapath u_dp (
        .clk     (clk),
        .clr     (start),
        .ctl     (ctl),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .op      (op),
        .pc      (pc),
        .bus     (bus),
        .out_val (out_val),
        .halted  (halted)
    );
endmodule

// File: rtl/acc_micro_chk.sv
module acc_micro_chk
    import acc_pkg::*;
(
    input logic          clk,
    input logic          start,
    input logic [NT-1:0] tst,
    input ctl_t          ctl,
    input logic [DW-1:0] bus,
    input logic [AW-1:0] pc,
    input logic [DW-1:0] out_val,
    input logic          halted
);
    logic [4:0] drv;
    assign drv = {ctl.pc_oe, ctl.mem_oe, ctl.ir_oe, ctl.acc_oe, ctl.alu_oe};

    a_r11_single_driver: assert property (@(posedge clk) disable iff (start)
        $onehot0(drv));

    a_r11_idle_bus_zero: assert property (@(posedge clk) disable iff (start)
        (drv == '0) |-> (bus == '0));

    a_r3_ring_onehot: assert property (@(posedge clk) disable iff (start)
        $onehot(tst));

    a_r1_clear_state: assert property (@(posedge clk)
        start |=> (pc == '0) && !halted && (out_val == '0) && tst[0]);

    a_r7_halt_freezes: assert property (@(posedge clk) disable iff (start)
        halted |=> halted && $stable(out_val) && $stable(pc) && $stable(tst));

    a_r4_output_only_t3: assert property (@(posedge clk) disable iff (start)
        (!$stable(out_val) && !$past(start)) |-> $past(tst[3]));
endmodule

bind acc_micro acc_micro_chk u_chk (
    .clk     (clk),
    .start   (start),
    .tst     (tst),
    .ctl     (ctl),
    .bus     (bus),
    .pc      (pc),
    .out_val (out_val),
    .halted  (halted)
);

// File: tb/acc_micro_tb.sv
module acc_micro_tb;

    logic       clk = 1'b0;
    logic       start = 1'b1;
    logic       ld_we = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] out_val;
    logic       halted;

    int checks = 0;
    int errors = 0;
    logic [7:0] img [16];

    always #4 clk = ~clk;

    acc_micro u_dut (
        .clk     (clk),
        .start   (start),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .out_val (out_val),
        .halted  (halted)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endtask

    // hold in clear and write the whole image
    task automatic load_img();
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < 16; i++) begin
            ld_we   = 1'b1;
            ld_addr = 4'(i);
            ld_data = img[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
    endtask

    task automatic release_start();
        start = 1'b0;
    endtask

    task automatic run_to_halt(output int edges);
        edges = 0;
        while (!halted && edges < 400) begin
            step(1);
            edges++;
        end
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 out_val in clear", out_val, 0);
        chk("R1 halted in clear", halted, 0);
    endtask

    task automatic t_sample_program();
        clear_img();
        img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'h1B; img[3] = 8'h1C;
        img[4] = 8'h2D; img[5] = 8'hE0; img[6] = 8'hF0;
        img[9] = 8'd16; img[10] = 8'd20; img[11] = 8'd24;
        img[12] = 8'd28; img[13] = 8'd32;
        load_img();
        chk("R1 out_val after preload", out_val, 0);
        release_start();
        step(33);
        chk("R4 out_val before output edge", out_val, 0);
        step(1);
        chk("R4 out_val on output edge 34", out_val, 56);
        step(5);
        chk("R3 not halted at edge 39", halted, 0);
        step(1);
        chk("R3 halted at edge 40", halted, 1);
        chk("R10 sample program result", out_val, 56);
    endtask

    task automatic t_halt_hold();
        int e;
        step(20);
        chk("R7 halted held", halted, 1);
        chk("R7 out_val frozen", out_val, 56);
        // halt first, operand nonzero
        clear_img();
        img[0] = 8'hF7;
        load_img();
        release_start();
        step(3);
        chk("R3 halt not yet at edge 3", halted, 0);
        step(1);
        chk("R3 R9 halt at edge 4", halted, 1);
        run_to_halt(e);
        chk("R7 out_val after early halt", out_val, 0);
    endtask

    task automatic t_add_wrap();
        int e;
        clear_img();
        img[0] = 8'h08; img[1] = 8'h19; img[2] = 8'hE0; img[3] = 8'hF0;
        img[8] = 8'd200; img[9] = 8'd100;
        load_img();
        release_start();
        run_to_halt(e);
        chk("R5 add modulo 256", out_val, 44);
        chk("R3 halt edge for 4th instruction", e, 22);
    endtask

    task automatic t_sub_wrap();
        int e;
        clear_img();
        img[0] = 8'h08; img[1] = 8'h29; img[2] = 8'hE0; img[3] = 8'hF0;
        img[8] = 8'd5; img[9] = 8'd10;
        load_img();
        release_start();
        run_to_halt(e);
        chk("R6 subtract modulo 256", out_val, 251);
    endtask

    task automatic t_nop_and_operand();
        int e;
        clear_img();
        img[0] = 8'h08; img[1] = 8'h37; img[2] = 8'h9C; img[3] = 8'hD9;
        img[4] = 8'hE7; img[5] = 8'hF3;
        img[7] = 8'h66; img[8] = 8'h5A; img[9] = 8'h01;
        load_img();
        release_start();
        step(3 * 6 + 4);
        chk("R8 no-ops leave out_val", out_val, 0);
        run_to_halt(e);
        chk("R8 R9 accumulator kept, operand ignored", out_val, 8'h5A);
    endtask

    task automatic t_preload_ignored();
        int e;
        clear_img();
        img[0] = 8'h08; img[1] = 8'hE0; img[2] = 8'hF0; img[8] = 8'h11;
        load_img();
        release_start();
        step(1);
        ld_we = 1'b1; ld_addr = 4'h8; ld_data = 8'h77;
        step(1);
        ld_addr = 4'h0; ld_data = 8'hF0;
        step(1);
        ld_we = 1'b0;
        run_to_halt(e);
        chk("R2 write during run ignored", out_val, 8'h11);
        start = 1'b1;
        step(2);
        release_start();
        run_to_halt(e);
        chk("R2 memory unchanged after rerun", out_val, 8'h11);
    endtask

    task automatic t_midrun_clear();
        int e;
        clear_img();
        img[0] = 8'h09; img[1] = 8'h1A; img[2] = 8'h1B; img[3] = 8'h1C;
        img[4] = 8'h2D; img[5] = 8'hE0; img[6] = 8'hF0;
        img[9] = 8'd16; img[10] = 8'd20; img[11] = 8'd24;
        img[12] = 8'd28; img[13] = 8'd32;
        load_img();
        release_start();
        step(36);
        chk("R12 output before clear", out_val, 56);
        start = 1'b1;
        step(1);
        chk("R12 out_val cleared", out_val, 0);
        chk("R12 halted cleared", halted, 0);
        release_start();
        run_to_halt(e);
        chk("R12 rerun from address 0 halt edge", e, 40);
        chk("R12 rerun result", out_val, 56);
    endtask

    initial begin
        t_reset();
        t_sample_program();
        t_halt_hold();
        t_add_wrap();
        t_sub_wrap();
        t_nop_and_operand();
        t_preload_ignored();
        t_midrun_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule